// File: doc/BRIEF.md
# Predicate-to-Bitmap Vector Packer

This block turns a predicate mask into a dense bitmap and writes that bitmap into a wide vector value. The vector is `VL` bits wide and the predicate is `VL/8` bits wide. A predicate holds one flag per vector element. An element of size `esize` bits therefore owns `esize/8` predicate bits, and only the lowest of those bits carries the flag. The packer gathers these flags into a run of `VL/esize` consecutive bits, with a 1 for a true element and a 0 for a false one.

The caller chooses which block of the destination receives the bitmap by giving a portion index. The block is `VL/esize` bits wide and starts at bit `index * VL/esize`. Index zero zeroes the rest of the destination. A non-zero index merges the bitmap into the current destination value, so every bit outside the block keeps its old value. An index outside the legal range for the chosen size raises a flag, and the destination then passes through unchanged.

Operands are captured on `op_valid`. The new vector appears with `res_valid` one clock later, and a new operation can start on every cycle.

Top module: `pred_bitmap_packer`

## Requirements
- R1: `elem_size` selects the element size: 2'b00 is 8-bit, 2'b01 is 16-bit, 2'b10 is 32-bit and 2'b11 is 64-bit. Bitmap bit e equals predicate bit `e * (esize/8)`. A predicate bit of 1 gives a bitmap bit of 1, and a predicate bit of 0 gives a bitmap bit of 0.
- R2: The bitmap holds `n = VL/esize` bits. For a legal index, result bits `[index*n + n - 1 : index*n]` hold the bitmap.
- R3: For a portion index of 0, every result bit outside the bitmap block is 0.
- R4: For a legal non-zero portion index, every result bit outside the bitmap block equals the corresponding bit of `dst_cur`.
- R5: The index is legal when it is below 2^`elem_size`: only 0 for 8-bit, 0..1 for 16-bit, 0..3 for 32-bit and 0..7 for 64-bit. All three index bits are checked. For an illegal index, `idx_bad` is 1 and `dst_new` equals `dst_cur`. For a legal index, `idx_bad` is 0.
- R6: An operation presented with `op_valid` high at a rising edge produces `res_valid` high and its result at the next rising edge. Back-to-back operations give back-to-back results.
- R7: While `rst_n` is low at a rising edge, `res_valid`, `idx_bad` and `dst_new` are cleared to 0.
- R8: In a cycle after `op_valid` was low, `res_valid` is 0, and `dst_new` and `idx_bad` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operands are valid this cycle |
| elem_size | input | 2 | Element size code |
| portion_idx | input | 3 | Destination block index |
| pred_in | input | VL/8 | Source predicate |
| dst_cur | input | VL | Current destination vector |
| res_valid | output | 1 | Result is valid |
| dst_new | output | VL | New destination vector |
| idx_bad | output | 1 | Index out of range for the chosen size |

## Verification
The clocked assertions assume that `op_valid` and the operand buses are stable around each rising edge. They also assume that the operands of a valid cycle are the ones the result is compared against one cycle later, so the high-bit checks compare `dst_new` with the previous `dst_cur`. The stimulus changes inputs only on falling edges and drives every size code and all eight index values, legal and illegal. Idle cycles are mixed into the stream, so the hold behaviour and back-to-back issue both occur.

// File: rtl/pvp_pkg.sv
// Package: shared constants and the element-size code for the packer.
// Assumes: the vector length is a power of two of at least 128.
package pvp_pkg;

    typedef enum logic [1:0] {
        ESZ_8  = 2'b00,
        ESZ_16 = 2'b01,
        ESZ_32 = 2'b10,
        ESZ_64 = 2'b11
    } esz_e;

    localparam int NUM_SIZES = 4;
    localparam int IDX_W     = 3;

endpackage

// File: rtl/pvp_gather.sv
// Module: pvp_gather
// Builds one packed bitmap per element size from the predicate. The bitmap
// for size code s takes every (2**s)-th predicate bit and zero-pads the top.
// Assumes: PL is divisible by 8, so every stride divides it exactly.
module pvp_gather #(
    parameter int PL = 32
) (
    input  logic [PL-1:0]                    pred,
    output logic [pvp_pkg::NUM_SIZES-1:0][PL-1:0] bitmaps
);
    for (genvar s = 0; s < pvp_pkg::NUM_SIZES; s++) begin : g_size
        localparam int N = PL >> s;
        for (genvar e = 0; e < PL; e++) begin : g_bit
            if (e < N) begin : g_take
                // Pick the flag bit of element e.
                assign bitmaps[s][e] = pred[e << s];
            end else begin : g_pad
                // Positions above the element count stay zero.
                assign bitmaps[s][e] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/pvp_place.sv
// Module: pvp_place
// Places each size's bitmap into its destination block, in zeroing or merging
// form, and selects the variant for the requested size. An illegal index
// passes the destination through and raises the flag.
// Assumes: the index is 3 bits wide; legality is index < 2**size_code.
module pvp_place #(
    parameter int VL = 256,
    parameter int PL = VL / 8
) (
    input  logic [1:0]                            esz,
    input  logic [pvp_pkg::IDX_W-1:0]             idx,
    input  logic [pvp_pkg::NUM_SIZES-1:0][PL-1:0] bitmaps,
    input  logic [VL-1:0]                         dst,
    output logic [VL-1:0]                         result,
    output logic                                  bad
);
    logic [pvp_pkg::NUM_SIZES-1:0][VL-1:0] placed;
    logic [pvp_pkg::NUM_SIZES-1:0]         legal;
    logic                                  zero_fill;

    assign zero_fill = (idx == '0);

    for (genvar s = 0; s < pvp_pkg::NUM_SIZES; s++) begin : g_var
        localparam int N = PL >> s;
        localparam logic [VL-1:0] FMASK = {{(VL-N){1'b0}}, {N{1'b1}}};
        logic [VL-1:0] bm_wide;
        logic [VL-1:0] keep;
        int            shamt;

        assign bm_wide = {{(VL-PL){1'b0}}, bitmaps[s]};
        assign shamt   = int'(idx) * N;
        // Index is legal when no bit at or above position s is set.
        assign legal[s] = ((idx >> s) == '0);

        // Keep the old bits outside the block, or nothing when zero-filling.
        always_comb begin
            keep = zero_fill ? '0 : (dst & ~(FMASK << shamt));
            placed[s] = keep | (bm_wide << shamt);
        end
    end

    // Choose the variant for the requested size, or pass through if illegal.
    always_comb begin
        bad    = !legal[esz];
        result = bad ? dst : placed[esz];
    end
endmodule

// File: rtl/pred_bitmap_packer.sv
// Module: pred_bitmap_packer (top)
// Packs predicate flags into a bitmap and writes it into a vector block. The
// result is registered: one cycle of latency, one operation per cycle.
// Assumes: VL is a power of two from 128 to 2048; reset is synchronous and
// active low.
module pred_bitmap_packer #(
    parameter int VL = 256,
    localparam int PL = VL / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [1:0]    elem_size,
    input  logic [2:0]    portion_idx,
    input  logic [PL-1:0] pred_in,
    input  logic [VL-1:0] dst_cur,
    output logic          res_valid,
    output logic [VL-1:0] dst_new,
    output logic          idx_bad
);
    logic [pvp_pkg::NUM_SIZES-1:0][PL-1:0] bitmaps;
    logic [VL-1:0]                         result_c;
    logic                                  bad_c;

    pvp_gather #(.PL(PL)) u_gather (
        .pred    (pred_in),
        .bitmaps (bitmaps)
    );

    pvp_place #(.VL(VL), .PL(PL)) u_place (
        .esz     (elem_size),
        .idx     (portion_idx),
        .bitmaps (bitmaps),
        .dst     (dst_cur),
        .result  (result_c),
        .bad     (bad_c)
    );

    // Valid strobe follows the input strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) res_valid <= 1'b0;
        else        res_valid <= op_valid;
    end

    // Result and flag are captured only for a valid operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_new <= '0;
            idx_bad <= 1'b0;
        end else if (op_valid) begin
            dst_new <= result_c;
            idx_bad <= bad_c;
        end
    end

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid); // R6
    AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(op_valid)); // R6
    AST_BAD_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && idx_bad) |-> (dst_new == $past(dst_cur))); // R5
    AST_BAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (idx_bad == (($past(portion_idx) >> $past(elem_size)) != 3'd0))); // R5
    AST_ZERO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !idx_bad && $past(portion_idx) == 3'd0)
            |-> (dst_new[VL-1:PL] == '0)); // R3
    AST_MERGE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !idx_bad && $past(portion_idx) != 3'd0)
            |-> (dst_new[VL-1:PL] == $past(dst_cur[VL-1:PL]))); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !$past(!rst_n)) |=> ($stable(dst_new) && $stable(idx_bad))); // R8
endmodule

// File: tb/pred_bitmap_packer_tb.sv
`timescale 1ns/1ps
module pred_bitmap_packer_tb;
    localparam int VL = 128;
    localparam int PL = VL / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [1:0]    elem_size = 2'b00;
    logic [2:0]    portion_idx = 3'd0;
    logic [PL-1:0] pred_in = '0;
    logic [VL-1:0] dst_cur = '0;
    logic          res_valid;
    logic [VL-1:0] dst_new;
    logic          idx_bad;

    int n_tests = 0;
    int n_fail  = 0;

    // Expectation for the operation issued in the previous cycle.
    logic          pend_v = 1'b0;
    logic [VL-1:0] pend_dst = '0;
    logic          pend_bad = 1'b0;
    int            pend_tag = 0;
    logic [VL-1:0] held_dst = '0;
    logic          held_bad = 1'b0;

    always #2.5 clk = ~clk;

    pred_bitmap_packer #(.VL(VL)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
        .elem_size(elem_size), .portion_idx(portion_idx),
        .pred_in(pred_in), .dst_cur(dst_cur),
        .res_valid(res_valid), .dst_new(dst_new), .idx_bad(idx_bad)
    );

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Expected result computed from R1..R5.
    task automatic model(input logic [1:0] s, input logic [2:0] i,
                         input logic [PL-1:0] p, input logic [VL-1:0] d,
                         output logic [VL-1:0] r, output logic b);
        int n;
        n = PL >> s;
        b = (int'(i) >= (1 << s));
        if (b) r = d;
        else begin
            r = (i == 3'd0) ? '0 : d;
            for (int e = 0; e < n; e++) r[int'(i) * n + e] = p[e << s];
        end
    endtask

    // Check the outputs of the previous cycle's operation or idle slot.
    task automatic check_prev();
        n_tests++;
        if (pend_v) begin
            if (res_valid !== 1'b1) begin
                n_fail++;
                $display("FAIL R6 res_valid act=%b exp=1", res_valid);
            end else if (idx_bad !== pend_bad) begin
                n_fail++;
                $display("FAIL R5 idx_bad act=%b exp=%b", idx_bad, pend_bad);
            end else if (dst_new !== pend_dst) begin
                n_fail++;
                if (pend_tag == 5)
                    $display("FAIL R5 dst_new act=%h exp=%h", dst_new, pend_dst);
                else if (pend_tag == 3)
                    $display("FAIL R1 R2 R3 dst_new act=%h exp=%h", dst_new, pend_dst);
                else
                    $display("FAIL R1 R2 R4 dst_new act=%h exp=%h", dst_new, pend_dst);
            end
            held_dst = pend_dst;
            held_bad = pend_bad;
        end else begin
            if (res_valid !== 1'b0 || dst_new !== held_dst || idx_bad !== held_bad) begin
                n_fail++;
                $display("FAIL R8 idle v=%b dst=%h bad=%b exp v=0 dst=%h bad=%b",
                         res_valid, dst_new, idx_bad, held_dst, held_bad);
            end
        end
    endtask

    task automatic step(input logic v, input logic [1:0] s, input logic [2:0] i,
                        input logic [PL-1:0] p, input logic [VL-1:0] d);
        logic [VL-1:0] r;
        logic          b;
        @(negedge clk);
        check_prev();
        op_valid = v; elem_size = s; portion_idx = i; pred_in = p; dst_cur = d;
        model(s, i, p, d, r, b);
        pend_v   = v;
        pend_dst = r;
        pend_bad = b;
        pend_tag = b ? 5 : ((i == 3'd0) ? 3 : 4);
    endtask

    function automatic logic [VL-1:0] rnd_vec();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        logic [PL-1:0] p;
        logic [VL-1:0] d;
        int cnt;
        cnt = 0;
        // R7: inputs look like a valid op during reset; outputs must stay clear.
        op_valid = 1'b1; dst_cur = '1; pred_in = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_tests++;
        if (res_valid !== 1'b0 || dst_new !== '0 || idx_bad !== 1'b0) begin
            n_fail++;
            $display("FAIL R7 reset v=%b dst=%h bad=%b exp 0", res_valid, dst_new, idx_bad);
        end
        op_valid = 1'b0;
        rst_n = 1'b1;
        // Full sweep of size code and index over several patterns (R1..R6).
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 8; i++) begin
                for (int k = 0; k < 6; k++) begin
                    case (k)
                        0: begin p = '0;              d = '1;        end
                        1: begin p = '1;              d = '0;        end
                        2: begin p = {(PL/2){2'b01}}; d = rnd_vec(); end
                        3: begin p = {(PL/2){2'b10}}; d = '1;        end
                        default: begin p = PL'($urandom); d = rnd_vec(); end
                    endcase
                    step(1'b1, 2'(s), 3'(i), p, d);
                    cnt++;
                    if (cnt % 7 == 0) step(1'b0, 2'(s), 3'(i), ~p, ~d); // R8 idle slot
                end
            end
        end
        step(1'b0, 2'b00, 3'd0, '0, '0);
        step(1'b0, 2'b00, 3'd0, '0, '0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule